// File: doc/BRIEF.md
# Masked-Match Instruction Decode Array

This block is the instruction decoder of a small 8-bit processor, built as an array of pattern rows rather than as a case statement. Each row stores two 8-bit opcode masks and a set of timing states. One mask lists the opcode bits that must be 1, the other lists the bits that must be 0, and bits named in neither mask are don't-care. A row fires when the opcode satisfies both masks and the one-hot timing vector shows a state that belongs to the row's set. Any number of rows may fire at once.

A second stage ORs the fired rows into named control strobes. These are address-low fetch, address-high fetch, load the internal bus into A, into X or into Y, next-opcode fetch, end of instruction, and branch-offset fetch. Because the rows overlap, an opcode that no row was written for can still satisfy several rows and receive their combined effect. Opcode 0xAF is the example here: in its third cycle it loads A and X together. When the branch-offset strobe fires, the branch condition fields of the opcode are also presented. The row table is a parameter. The default table covers the absolute-load family and the first cycle of conditional branches. The row vector, the strobes and the branch fields are registered, so every output follows its inputs by one clock.

Top module: `dec_array`

## Requirements
- R1: `row_hit_o` bit i is high when default row i fired. The rows are: 0 = 101011XX in T1, 1 = 101011XX in T2, 2 = 101011XX in T4, 3 = 10101100 in T3, 4 = 101011X1 in T3, 5 = 1010111X in T3, 6 = XXX10000 in T1. Timing bit k of `tstate_i` stands for state T(k+1).
- R2: A row fires only when all of its ON bits are 1, all of its OFF bits are 0, and the active timing state is in its set. An all-zero timing vector fires no row.
- R3: All outputs are registered with one clock of latency. While `rst_n` is low, every output is 0.
- R4: `ctl_o` bits 2, 3 and 4 are load-into-A, load-into-X and load-into-Y. In T3, 0xAC raises only Y, 0xAD raises only A, and 0xAE raises only X.
- R5: In T3, opcode 0xAF raises exactly two load strobes, A and X, in the same cycle.
- R6: For opcodes 101011XX, `ctl_o` bit 0 (address low) is high in T1, bit 1 (address high) is high in T2, and bit 5 (next opcode) together with bit 6 (end of instruction) is high in T4.
- R7: For pattern XXX10000 in T1, `ctl_o` bit 7 (branch offset) is high. In that cycle `br_flag_o` carries opcode bits 7:6 (00=N, 01=V, 10=C, 11=Z) and `br_sense_o` carries opcode bit 5 (1 = taken on set). Both fields are 0 whenever bit 7 is low.
- R8: An opcode and timing state that match no row give an all-zero `ctl_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode_i | input | 8 | Current opcode |
| tstate_i | input | 6 | One-hot timing state, bit k = T(k+1) |
| row_hit_o | output | NUM_ROWS | Registered raw row fire vector |
| ctl_o | output | 8 | Registered merged control strobes |
| br_flag_o | output | 2 | Branch condition flag select |
| br_sense_o | output | 1 | Branch taken-on-set polarity |

## Verification
A wrong mask bit or timing set in a row shows at the ports one clock after the offending opcode and state are applied. It appears either as a row bit that differs from the expected pattern, or as a strobe firing in a state it does not belong to. Every opcode is therefore swept against every timing state, plus the empty state, and the registered outputs are compared with a behavioural model on the following clock. A merge fault that drops the OR of two rows shows only for opcodes that satisfy several rows, so 0xAF in T3 is checked on its own for exactly two load strobes.

// File: rtl/dec_pkg.sv
package dec_pkg;

    localparam int OP_W  = 8;
    localparam int T_W   = 6;
    localparam int CTL_W = 8;

    // control strobe bit positions
    localparam int CB_ADDR_LO = 0;
    localparam int CB_ADDR_HI = 1;
    localparam int CB_LOAD_A  = 2;
    localparam int CB_LOAD_X  = 3;
    localparam int CB_LOAD_Y  = 4;
    localparam int CB_NEXT_OP = 5;
    localparam int CB_END_INS = 6;
    localparam int CB_BR_OFS  = 7;

    typedef struct packed {
        logic [OP_W-1:0]  on_bits;
        logic [OP_W-1:0]  off_bits;
        logic [T_W-1:0]   tset;
        logic [CTL_W-1:0] ctl;
    } dec_row_t;

    localparam int DEF_ROWS = 7;

    localparam dec_row_t [DEF_ROWS-1:0] DEF_TABLE = '{
        0: '{on_bits: 8'hAC, off_bits: 8'h50, tset: 6'b000001, ctl: 8'b0000_0001},
        1: '{on_bits: 8'hAC, off_bits: 8'h50, tset: 6'b000010, ctl: 8'b0000_0010},
        2: '{on_bits: 8'hAC, off_bits: 8'h50, tset: 6'b001000, ctl: 8'b0110_0000},
        3: '{on_bits: 8'hAC, off_bits: 8'h53, tset: 6'b000100, ctl: 8'b0001_0000},
        4: '{on_bits: 8'hAD, off_bits: 8'h50, tset: 6'b000100, ctl: 8'b0000_0100},
        5: '{on_bits: 8'hAE, off_bits: 8'h50, tset: 6'b000100, ctl: 8'b0000_1000},
        6: '{on_bits: 8'h10, off_bits: 8'h0F, tset: 6'b000001, ctl: 8'b1000_0000}
    };

endpackage

// File: rtl/dec_row_match.sv
module dec_row_match
    import dec_pkg::*;
#(
    parameter dec_row_t ROW = '0
) (
    input  logic [OP_W-1:0] opcode,
    input  logic [T_W-1:0]  tstate,
    output logic            hit
);
    logic on_ok;
    logic off_ok;
    logic t_ok;

    always_comb begin
        on_ok  = ((opcode & ROW.on_bits) == ROW.on_bits);
        off_ok = ((~opcode & ROW.off_bits) == ROW.off_bits);
        t_ok   = |(tstate & ROW.tset);
        hit    = on_ok && off_ok && t_ok;
    end
endmodule

// File: rtl/dec_ctl_merge.sv
module dec_ctl_merge
    import dec_pkg::*;
#(
    parameter int                           NUM_ROWS = DEF_ROWS,
    parameter dec_row_t [NUM_ROWS-1:0]      TABLE    = DEF_TABLE
) (
    input  logic [NUM_ROWS-1:0] hits,
    output logic [CTL_W-1:0]    ctl
);
    logic [CTL_W-1:0] contrib [NUM_ROWS];

    for (genvar g = 0; g < NUM_ROWS; g++) begin : g_contrib
        assign contrib[g] = hits[g] ? TABLE[g].ctl : '0;
    end

    always_comb begin
        ctl = '0;
        for (int i = 0; i < NUM_ROWS; i++) begin
            ctl = ctl | contrib[i];
        end
    end
endmodule

// File: rtl/dec_branch_field.sv
module dec_branch_field
    import dec_pkg::*;
(
    input  logic            br_fire,
    input  logic [OP_W-1:0] opcode,
    output logic [1:0]      flag_sel,
    output logic            sense
);
    always_comb begin
        flag_sel = br_fire ? opcode[7:6] : 2'b00;
        sense    = br_fire ? opcode[5]   : 1'b0;
    end
endmodule

// File: rtl/dec_array.sv
module dec_array
    import dec_pkg::*;
#(
    parameter int                      NUM_ROWS  = DEF_ROWS,
    parameter dec_row_t [NUM_ROWS-1:0] ROW_TABLE = DEF_TABLE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [OP_W-1:0]     opcode_i,
    input  logic [T_W-1:0]      tstate_i,
    output logic [NUM_ROWS-1:0] row_hit_o,
    output logic [CTL_W-1:0]    ctl_o,
    output logic [1:0]          br_flag_o,
    output logic                br_sense_o
);
    typedef struct packed {
        logic [NUM_ROWS-1:0] rows;
        logic [CTL_W-1:0]    ctl;
        logic [1:0]          flag;
        logic                sense;
    } dec_state_t;

    dec_state_t st_d;
    dec_state_t st_q;

    logic [NUM_ROWS-1:0] hits;
    logic [CTL_W-1:0]    ctl_comb;
    logic [1:0]          flag_comb;
    logic                sense_comb;

    for (genvar g = 0; g < NUM_ROWS; g++) begin : g_row
        dec_row_match #(.ROW(ROW_TABLE[g])) u_row (
            .opcode (opcode_i),
            .tstate (tstate_i),
            .hit    (hits[g])
        );
    end

    dec_ctl_merge #(.NUM_ROWS(NUM_ROWS), .TABLE(ROW_TABLE)) u_merge (
        .hits (hits),
        .ctl  (ctl_comb)
    );

    dec_branch_field u_br (
        .br_fire  (ctl_comb[CB_BR_OFS]),
        .opcode   (opcode_i),
        .flag_sel (flag_comb),
        .sense    (sense_comb)
    );

    always_comb begin
        st_d       = st_q;
        st_d.rows  = hits;
        st_d.ctl   = ctl_comb;
        st_d.flag  = flag_comb;
        st_d.sense = sense_comb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign row_hit_o  = st_q.rows;
    assign ctl_o      = st_q.ctl;
    assign br_flag_o  = st_q.flag;
    assign br_sense_o = st_q.sense;
endmodule

// File: rtl/dec_array_chk.sv
module dec_array_chk #(
    parameter int NUM_ROWS = 7
) (
    input logic                clk,
    input logic                rst_n,
    input logic [7:0]          opcode_i,
    input logic [5:0]          tstate_i,
    input logic [NUM_ROWS-1:0] row_hit_o,
    input logic [7:0]          ctl_o,
    input logic [1:0]          br_flag_o,
    input logic                br_sense_o
);
    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    AST_IDLE_T_NO_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(tstate_i) == 6'b0) |-> row_hit_o == '0); // R2

    AST_LOAD_ONLY_T3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && |ctl_o[4:2]) |-> $past(tstate_i[2])); // R4

    AST_LOAD_A_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && ctl_o[2]) |-> ($past(opcode_i[7:2]) == 6'b101011 && $past(opcode_i[0]))); // R4

    AST_LOAD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ctl_o[4:2]) <= 2); // R5

    AST_BRANCH_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && ctl_o[7]) |-> (br_flag_o == $past(opcode_i[7:6]) && br_sense_o == $past(opcode_i[5]))); // R7

    AST_BRANCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_o[7] |-> (br_flag_o == 2'b00 && !br_sense_o)); // R7

    AST_NO_HIT_NO_CTL: assert property (@(posedge clk) disable iff (!rst_n)
        (row_hit_o == '0) |-> ctl_o == 8'h00); // R8

    always_comb begin
        if (!rst_n) begin
            AST_RESET_CLEAR: assert (row_hit_o == '0 && ctl_o == 8'h00); // R3
        end
    end
endmodule

bind dec_array dec_array_chk #(.NUM_ROWS(NUM_ROWS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .opcode_i   (opcode_i),
    .tstate_i   (tstate_i),
    .row_hit_o  (row_hit_o),
    .ctl_o      (ctl_o),
    .br_flag_o  (br_flag_o),
    .br_sense_o (br_sense_o)
);

// File: tb/dec_array_test.sv
`timescale 1ns/1ps
module dec_array_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] opcode_i = 8'h00;
    logic [5:0] tstate_i = 6'b0;
    logic [6:0] row_hit_o;
    logic [7:0] ctl_o;
    logic [1:0] br_flag_o;
    logic       br_sense_o;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #2.5 clk = ~clk;

    dec_array uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .opcode_i   (opcode_i),
        .tstate_i   (tstate_i),
        .row_hit_o  (row_hit_o),
        .ctl_o      (ctl_o),
        .br_flag_o  (br_flag_o),
        .br_sense_o (br_sense_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // behavioural reference: state index 1..6, 0 means no state
    function automatic logic [6:0] ref_rows(input logic [7:0] op, input int ts);
        logic abs_fam;
        logic [6:0] r;
        abs_fam = (op == 8'hAC) || (op == 8'hAD) || (op == 8'hAE) || (op == 8'hAF);
        r = '0;
        r[0] = abs_fam && ts == 1;
        r[1] = abs_fam && ts == 2;
        r[2] = abs_fam && ts == 4;
        r[3] = (op == 8'hAC) && ts == 3;
        r[4] = (op == 8'hAD || op == 8'hAF) && ts == 3;
        r[5] = (op == 8'hAE || op == 8'hAF) && ts == 3;
        r[6] = (op % 32 == 16) && ts == 1;
        return r;
    endfunction

    function automatic logic [7:0] ref_ctl(input logic [7:0] op, input int ts);
        logic [6:0] r;
        r = ref_rows(op, ts);
        return {r[6], r[2], r[2], r[3], r[5], r[4], r[1], r[0]};
    endfunction

    task automatic apply(input logic [7:0] op, input int ts);
        @(negedge clk);
        opcode_i = op;
        tstate_i = (ts == 0) ? 6'b0 : 6'(1 << (ts - 1));
        @(negedge clk);
    endtask

    task automatic compare(input logic [7:0] op, input int ts);
        logic [7:0] ec;
        ec = ref_ctl(op, ts);
        chk("R1", $sformatf("rows op=%02h t=%0d", op, ts), int'(row_hit_o), int'(ref_rows(op, ts)));
        chk("R6", $sformatf("addr/next op=%02h t=%0d", op, ts), int'({ctl_o[6:5], ctl_o[1:0]}), int'({ec[6:5], ec[1:0]}));
        chk("R4", $sformatf("loads op=%02h t=%0d", op, ts), int'(ctl_o[4:2]), int'(ec[4:2]));
        chk("R7", $sformatf("branch op=%02h t=%0d", op, ts),
            int'({ctl_o[7], br_flag_o, br_sense_o}),
            int'(ec[7] ? {1'b1, op[7:6], op[5]} : 4'b0));
        if (ref_rows(op, ts) == '0)
            chk("R8", $sformatf("no match op=%02h t=%0d", op, ts), int'(ctl_o), 0);
    endtask

    initial begin
        opcode_i = 8'hAF;
        tstate_i = 6'b000100;
        repeat (3) @(negedge clk);
        chk("R3", "reset rows", int'(row_hit_o), 0);
        chk("R3", "reset ctl", int'(ctl_o), 0);
        rst_n = 1'b1;

        // R3: latency of one clock
        @(negedge clk);
        opcode_i = 8'hAD;
        tstate_i = 6'b000100;
        @(posedge clk);
        #1;
        chk("R3", "one-cycle latency load A", int'(ctl_o[2]), 1);
        opcode_i = 8'h00;
        @(negedge clk);
        chk("R3", "output held until next edge", int'(ctl_o[2]), 1);

        // R4 / R5 named T3 cases
        apply(8'hAC, 3);
        chk("R4", "0xAC T3 loads", int'(ctl_o[4:2]), 3'b100);
        apply(8'hAD, 3);
        chk("R4", "0xAD T3 loads", int'(ctl_o[4:2]), 3'b001);
        apply(8'hAE, 3);
        chk("R4", "0xAE T3 loads", int'(ctl_o[4:2]), 3'b010);
        apply(8'hAF, 3);
        chk("R5", "0xAF T3 load count", $countones(ctl_o[4:2]), 2);
        chk("R5", "0xAF T3 loads", int'(ctl_o[4:2]), 3'b011);

        // R6 sequence for 0xAF
        apply(8'hAF, 1);
        chk("R6", "0xAF T1 addr lo", int'(ctl_o), 8'h01);
        apply(8'hAF, 2);
        chk("R6", "0xAF T2 addr hi", int'(ctl_o), 8'h02);
        apply(8'hAF, 4);
        chk("R6", "0xAF T4 next+end", int'(ctl_o), 8'h60);

        // R7 branch cases
        apply(8'hF0, 1);
        chk("R7", "0xF0 T1 branch", int'({ctl_o[7], br_flag_o, br_sense_o}), 4'b1111);
        apply(8'h50, 1);
        chk("R7", "0x50 T1 branch", int'({ctl_o[7], br_flag_o, br_sense_o}), 4'b1010);
        apply(8'hF0, 2);
        chk("R7", "0xF0 T2 no branch", int'({ctl_o[7], br_flag_o, br_sense_o}), 0);

        // R2 / R8: empty timing state and unmatched opcodes
        apply(8'hAF, 0);
        chk("R2", "0xAF no state", int'(row_hit_o), 0);
        apply(8'h2F, 3);
        chk("R8", "0x2F T3 unmatched", int'(ctl_o), 0);

        // full sweep against the reference model
        for (int op = 0; op < 256; op++) begin
            for (int ts = 0; ts <= 6; ts++) begin
                apply(8'(op), ts);
                compare(8'(op), ts);
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(5 * 100000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule